// File: doc/BRIEF.md
# Sparse Event Row Readout

This block reads out one row of photon-timing pixels in a receiver that decodes pulse-position-modulated light. Each pixel is shown here only as a hit pulse and a timestamp bus, and the block holds the state behind them. While a pixel is armed, its first hit is latched together with the timestamp present in that cycle. Further hits are then ignored until the row is queried.

A query is accepted only when no earlier readout is still in progress. When it is accepted, the row's fire state is captured in a single cycle. One word with a bit per column goes out on a map stream. After that word has been taken, a packet stream sends one packet for each fired column that is not muted. Each packet carries the column number and its timestamp. Columns that did not fire add no cycles to the packet stream, and they stay armed throughout. Every column that reported goes into a programmable quench hold-off before it can arm again. Per-column configuration can shut a pixel off completely, or keep it in the map while removing its packet.

Top module: `sparse_row_readout`

## Requirements
- R1: After reset, and with no query, both map_valid and pkt_valid are low.
- R2: When a query is accepted at a clock edge, map_valid is high from that edge on. Bit i of map_data is 1 exactly when column i latched a hit after it last armed and cfg_disable[i] was low at the accepting edge. A row with no hits still sends a map word, which is then zero.
- R3: Packets go out only after the map word of the same readout has been accepted. There is exactly one packet for each reported column that is not muted, in ascending column order. pkt_data[14:10] is the column and pkt_data[9:0] is its latched timestamp.
- R4: While a valid is high and its ready is low, the valid stays high and its data does not change.
- R5: A column with cfg_mask[i] high at the accepting edge shows up in the map word but sends no packet.
- R6: A column with cfg_disable[i] high does not arm. Hits on it are dropped, so it never appears in a map word or a packet.
- R7: A column that did not report stays armed through a readout. A hit that lands on it while the readout is still running is kept and shows up in the next readout.
- R8: A reported column ignores hits for cfg_holdoff cycles after the accepting edge. With H = cfg_holdoff and the accepting edge counted as edge 0, a hit sampled at edge H is dropped and a hit sampled at edge H+1 is latched. This holds provided the column's packet has already been sent.
- R9: A query that arrives while a map word or any packet is still pending is ignored. It changes neither the current readout nor the hits waiting for the next one.
- R10: A second hit on an already latched column does not overwrite the first timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_query | input | 1 | Request to read out the row |
| pix_hit | input | 32 | Per-column detection pulse |
| pix_ts | input | 320 | Per-column timestamp, 10 bits per column, column 0 in the lowest bits |
| cfg_disable | input | 32 | Per-column shut-off |
| cfg_mask | input | 32 | Per-column packet mute |
| cfg_holdoff | input | 8 | Quench hold-off length in cycles |
| map_valid | output | 1 | Fire map word valid |
| map_ready | input | 1 | Fire map word accepted |
| map_data | output | 32 | Fire map word, one bit per column |
| pkt_valid | output | 1 | Timestamp packet valid |
| pkt_ready | input | 1 | Timestamp packet accepted |
| pkt_data | output | 15 | {column[4:0], timestamp[9:0]} |

## Verification
The assertions assume that the consumers never drop a valid on their own. They also assume that cfg_disable and cfg_mask are meaningful at the accepting edge, and that the disable check looks back exactly one cycle to that edge. The bench follows these rules: it changes configuration only between readouts and drives hits only on the falling clock edge. It sweeps every single column, a long series of pseudo-random hit patterns with fixed mute and shut-off sets, and ready patterns with and without stalls. The hold-off boundary is tested by counting edges from the accepting edge.

// File: rtl/srr_pkg.sv
package srr_pkg;
    localparam int unsigned DEF_COLS   = 32;
    localparam int unsigned DEF_TS_W   = 10;
    localparam int unsigned DEF_HOLD_W = 8;
endpackage

// File: rtl/srr_pixel_slot.sv
module srr_pixel_slot #(
    parameter int unsigned TS_W   = 10,
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic [TS_W-1:0]   ts_i,
    input  logic              off_i,
    input  logic              clear_i,
    input  logic              block_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              fired_o,
    output logic [TS_W-1:0]   ts_o
);
    typedef struct packed {
        logic              fired;
        logic [TS_W-1:0]   ts;
        logic [HOLD_W-1:0] hold;
    } slot_t;

    slot_t s_d, s_q;
    logic  armed;

    always_comb begin
        s_d   = s_q;
        armed = !off_i && (s_q.hold == '0) && !s_q.fired && !block_i;
        if (s_q.hold != '0) begin
            s_d.hold = s_q.hold - HOLD_W'(1);
        end
        if (off_i) begin
            s_d.fired = 1'b0;
        end else if (clear_i) begin
            // reported: drop the event and start the quench wait
            s_d.fired = 1'b0;
            s_d.hold  = holdoff_i;
        end else if (armed && hit_i) begin
            s_d.fired = 1'b1;
            s_d.ts    = ts_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fired_o = s_q.fired;
    assign ts_o    = s_q.ts;
endmodule

// File: rtl/srr_first_set.sv
module srr_first_set #(
    parameter int unsigned N  = 32,
    parameter int unsigned IW = 5
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
        found_o = |vec_i;
    end
endmodule

// File: rtl/sparse_row_readout.sv
module sparse_row_readout #(
    parameter int unsigned COLS   = srr_pkg::DEF_COLS,
    parameter int unsigned TS_W   = srr_pkg::DEF_TS_W,
    parameter int unsigned HOLD_W = srr_pkg::DEF_HOLD_W,
    localparam int unsigned COL_W = $clog2(COLS),
    localparam int unsigned PKT_W = COL_W + TS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 row_query,
    input  logic [COLS-1:0]      pix_hit,
    input  logic [COLS*TS_W-1:0] pix_ts,
    input  logic [COLS-1:0]      cfg_disable,
    input  logic [COLS-1:0]      cfg_mask,
    input  logic [HOLD_W-1:0]    cfg_holdoff,
    output logic                 map_valid,
    input  logic                 map_ready,
    output logic [COLS-1:0]      map_data,
    output logic                 pkt_valid,
    input  logic                 pkt_ready,
    output logic [PKT_W-1:0]     pkt_data
);
    typedef struct packed {
        logic            map_vld;
        logic [COLS-1:0] map_word;
        logic [COLS-1:0] pend;
    } row_t;

    row_t r_d, r_q;

    logic [COLS-1:0]            fired;
    logic [COLS-1:0][TS_W-1:0]  ts_arr;
    logic [COLS-1:0]            report;
    logic [COLS-1:0]            clear;
    logic                       accept;
    logic                       any_pend;
    logic [COL_W-1:0]           sel;

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            srr_pixel_slot #(.TS_W(TS_W), .HOLD_W(HOLD_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .hit_i     (pix_hit[c]),
                .ts_i      (pix_ts[c*TS_W +: TS_W]),
                .off_i     (cfg_disable[c]),
                .clear_i   (clear[c]),
                .block_i   (r_q.pend[c]),
                .holdoff_i (cfg_holdoff),
                .fired_o   (fired[c]),
                .ts_o      (ts_arr[c])
            );
        end
    endgenerate

    srr_first_set #(.N(COLS), .IW(COL_W)) u_pick (
        .vec_i   (r_q.pend),
        .found_o (any_pend),
        .idx_o   (sel)
    );

    always_comb begin
        r_d    = r_q;
        accept = row_query && !r_q.map_vld && !any_pend;
        report = fired & ~cfg_disable;
        clear  = accept ? report : '0;
        if (accept) begin
            r_d.map_vld  = 1'b1;
            r_d.map_word = report;
            r_d.pend     = report & ~cfg_mask;
        end else begin
            if (r_q.map_vld && map_ready) begin
                r_d.map_vld = 1'b0;
            end
            if (any_pend && !r_q.map_vld && pkt_ready) begin
                r_d.pend[sel] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign map_valid = r_q.map_vld;
    assign map_data  = r_q.map_word;
    assign pkt_valid = any_pend && !r_q.map_vld;
    assign pkt_data  = {sel, ts_arr[sel]};
endmodule

// File: rtl/sparse_row_readout_chk.sv
module sparse_row_readout_chk #(
    parameter int unsigned COLS  = 32,
    parameter int unsigned COL_W = 5,
    parameter int unsigned TS_W  = 10,
    localparam int unsigned PKT_W = COL_W + TS_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [COLS-1:0]  cfg_disable,
    input logic             map_valid,
    input logic             map_ready,
    input logic [COLS-1:0]  map_data,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [PKT_W-1:0] pkt_data
);
    p_map_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && !map_ready) |=> (map_valid && $stable(map_data)));

    p_pkt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

    p_map_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !map_valid);

    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=>
            (!pkt_valid || (pkt_data[PKT_W-1:TS_W] > $past(pkt_data[PKT_W-1:TS_W]))));

    p_pkt_in_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> map_data[pkt_data[PKT_W-1:TS_W]]);

    p_off_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_valid) |-> ((map_data & $past(cfg_disable)) == '0));
endmodule

bind sparse_row_readout sparse_row_readout_chk #(
    .COLS(COLS), .COL_W(COL_W), .TS_W(TS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_disable (cfg_disable),
    .map_valid   (map_valid),
    .map_ready   (map_ready),
    .map_data    (map_data),
    .pkt_valid   (pkt_valid),
    .pkt_ready   (pkt_ready),
    .pkt_data    (pkt_data)
);

// File: tb/tb_sparse_row_readout.sv
module tb_sparse_row_readout;
    localparam int NP = 32;
    localparam int TW = 10;
    localparam int PW = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            row_query = 1'b0;
    logic [NP-1:0]   pix_hit = '0;
    logic [NP*TW-1:0] pix_ts = '0;
    logic [NP-1:0]   cfg_disable = '0;
    logic [NP-1:0]   cfg_mask = '0;
    logic [7:0]      cfg_holdoff = 8'd2;
    logic            map_valid, pkt_valid;
    logic            map_ready = 1'b0, pkt_ready = 1'b0;
    logic [NP-1:0]   map_data;
    logic [PW-1:0]   pkt_data;

    int nvec = 0;
    int nerr = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    sparse_row_readout dut (
        .clk(clk), .rst_n(rst_n), .row_query(row_query), .pix_hit(pix_hit),
        .pix_ts(pix_ts), .cfg_disable(cfg_disable), .cfg_mask(cfg_mask),
        .cfg_holdoff(cfg_holdoff), .map_valid(map_valid), .map_ready(map_ready),
        .map_data(map_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_data(pkt_data)
    );

    function automatic logic [TW-1:0] ts_val(input int col, input int k);
        return TW'((col * 37 + k * 11 + 5) % 1024);
    endfunction

    function automatic logic [NP*TW-1:0] ts_all(input int k);
        logic [NP*TW-1:0] v;
        for (int i = 0; i < NP; i++) v[i*TW +: TW] = ts_val(i, k);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h0400_0007 : 32'h0);
    endtask

    task automatic inject(input logic [NP-1:0] v, input int k);
        @(negedge clk);
        pix_hit = v;
        pix_ts  = ts_all(k);
        @(negedge clk);
        pix_hit = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // query with free-running consumers, output not inspected; ends at negedge after accepting edge
    task automatic query_only();
        @(negedge clk);
        row_query = 1'b1; map_ready = 1'b1; pkt_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        row_query = 1'b0;
    endtask

    task automatic readout(input logic [NP-1:0] exp_map, input logic [NP-1:0] exp_pk,
                           input int kts, input logic [NP-1:0] inj, input int kinj,
                           input bit spurious, input bit stall, input string tag);
        logic [NP-1:0] left;
        logic [NP-1:0] pm_d;
        logic [PW-1:0] pp_d;
        bit got_map, pm_v, pm_r, pp_v, pp_r, mr, pr;
        int cyc, col;
        left = exp_pk; got_map = 0; cyc = 0;
        pm_v = 0; pm_r = 1; pp_v = 0; pp_r = 1; pm_d = '0; pp_d = '0;
        @(negedge clk);
        row_query = 1'b1; map_ready = 1'b0; pkt_ready = 1'b0;
        @(negedge clk);
        row_query = 1'b0;
        while (!(got_map && left == '0) && cyc < 400) begin
            step_lfsr();
            mr = stall ? lfsr[0] : 1'b1;
            pr = stall ? lfsr[3] : 1'b1;
            if (spurious && cyc < 3) mr = 1'b0;
            row_query = (spurious && cyc == 1);
            if (cyc == 0 && inj != '0) begin
                pix_hit = inj; pix_ts = ts_all(kinj);
            end else begin
                pix_hit = '0;
            end
            if (pm_v && !pm_r)
                chk(map_valid && map_data == pm_d, {tag, " R4 map stall"}, map_data, pm_d);
            if (pp_v && !pp_r)
                chk(pkt_valid && pkt_data == pp_d, {tag, " R4 pkt stall"}, pkt_data, pp_d);
            if (pkt_valid && !got_map)
                chk(1'b0, {tag, " R3 packet before map"}, pkt_data, 0);
            if (map_valid && got_map)
                chk(1'b0, {tag, " R9 second map word"}, map_data, 0);
            if (map_valid && mr) begin
                chk(map_data == exp_map, {tag, " R2 map word"}, map_data, exp_map);
                got_map = 1;
            end
            if (pkt_valid && pr && got_map) begin
                col = -1;
                for (int i = NP - 1; i >= 0; i--) if (left[i]) col = i;
                if (col < 0) begin
                    chk(1'b0, {tag, " R3 extra packet"}, pkt_data, 0);
                end else begin
                    chk(pkt_data == {5'(col), ts_val(col, kts)}, {tag, " R3 packet"},
                        pkt_data, {5'(col), ts_val(col, kts)});
                    left[col] = 1'b0;
                end
            end
            map_ready = mr; pkt_ready = pr;
            pm_v = map_valid; pm_r = mr; pm_d = map_data;
            pp_v = pkt_valid; pp_r = pr; pp_d = pkt_data;
            cyc++;
            @(negedge clk);
        end
        chk(cyc < 400, {tag, " R3 readout completes"}, cyc, 400);
        row_query = 1'b0; pix_hit = '0; map_ready = 1'b1; pkt_ready = 1'b1;
        for (int j = 0; j < 3; j++) begin
            chk(!map_valid && !pkt_valid, {tag, " R3 stream idle after row"},
                {map_valid, pkt_valid}, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [NP-1:0] h;
        repeat (3) @(negedge clk);
        chk(!map_valid && !pkt_valid, "R1 in reset", {map_valid, pkt_valid}, 0);
        rst_n = 1'b1;
        idle(3);
        chk(!map_valid && !pkt_valid, "R1 after reset", {map_valid, pkt_valid}, 0);

        // R2 R3: every single column
        for (int c = 0; c < NP; c++) begin
            inject(NP'(1) << c, c);
            readout(NP'(1) << c, NP'(1) << c, c, '0, 0, 0, c[0], "single");
            idle(3);
        end

        // R2: empty row still gives a zero map word
        readout('0, '0, 0, '0, 0, 0, 0, "empty");

        // R5 R6 R4: pseudo-random patterns with mute and shut-off sets
        cfg_mask    = 32'h0F0F_00F0;
        cfg_disable = 32'h8000_0101;
        for (int t = 0; t < 24; t++) begin
            step_lfsr();
            h = lfsr;
            if (t == 0) h = '1;
            inject(h, 40 + t);
            readout(h & ~cfg_disable, h & ~cfg_disable & ~cfg_mask, 40 + t, '0, 0, 0,
                    t[0], "R5R6 sweep");
            idle(3);
        end
        cfg_mask = '0;
        cfg_disable = '0;
        idle(2);

        // R10: second hit keeps first timestamp
        inject(32'h00F0_0F01, 100);
        inject(32'h00F0_0F01, 101);
        readout(32'h00F0_0F01, 32'h00F0_0F01, 100, '0, 0, 0, 1, "R10");
        idle(4);

        // R7 R9: hits on idle columns during readout, spurious query while map stalled
        cfg_holdoff = 8'd60;
        inject(32'h0000_FFFF, 110);
        readout(32'h0000_FFFF, 32'h0000_FFFF, 110, 32'hFFFF_FFFF, 111, 1, 0, "R7R9 first");
        readout(32'hFFFF_0000, 32'hFFFF_0000, 111, '0, 0, 0, 1, "R7R9 second");
        idle(80);

        // R8: hold-off boundary on column 5
        cfg_holdoff = 8'd20;
        inject(32'h20, 120);
        query_only();
        repeat (19) @(posedge clk);
        @(negedge clk);
        pix_hit = 32'h20; pix_ts = ts_all(121);
        @(negedge clk);
        pix_hit = '0;
        idle(5);
        readout('0, '0, 0, '0, 0, 0, 0, "R8 hit at edge H dropped");
        idle(30);
        inject(32'h20, 122);
        query_only();
        repeat (20) @(posedge clk);
        @(negedge clk);
        pix_hit = 32'h20; pix_ts = ts_all(123);
        @(negedge clk);
        pix_hit = '0;
        idle(5);
        readout(32'h20, 32'h20, 123, '0, 0, 0, 0, "R8 hit at edge H+1 kept");
        idle(30);

        // R6: a latched hit is dropped when its column is shut off before the query
        cfg_holdoff = 8'd2;
        inject(32'h0000_0300, 130);
        @(negedge clk);
        cfg_disable = 32'h0000_0100;
        idle(2);
        readout(32'h0000_0200, 32'h0000_0200, 130, '0, 0, 0, 0, "R6 late shut-off");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule